// File: doc/BRIEF.md
# Paged Autoincrementing Graphics ROM Port

This block is one slice of a byte-serial graphics ROM that sits on a shared 8-bit CPU data bus. Up to eight slices can share one chip enable, two mode lines and the data lines. Each slice carries a fixed 3-bit page number, set by a parameter. Inside each slice is a 6144-byte ROM. Its contents come from a fixed formula, so no stored table is needed. A 16-bit address register is loaded one byte at a time. The top 3 bits of that register pick a page, and the low 13 bits pick a byte.

Every slice sees every operation and updates its own address register in the same way. This keeps all slices in step. The page field only decides whether a slice drives a data byte onto the bus during a data read. Reads of the address register are driven by every slice. Because the slices are in step, they all drive the same value.

Each operation is one cycle of chip enable low while READY is high. READY then drops for a fixed two-cycle access window. During that window a read result is held on the output.

Top module: `paged_rom_port`

## Requirements
- R1: After reset the address register is 0x0000, the byte toggle selects the first (high) byte, `ready` is 1 and `dout_oe` is 0.
- R2: Address bits [15:13] form the page field. The slice is the current page exactly when this field equals its `PAGE_ID` parameter.
- R3: A data read (mode 2'b01) outputs ROM byte f(idx, PAGE_ID) = ((idx*37) ^ (idx>>5) ^ (PAGE_ID*69)) mod 256 for the mapped index. `dout_oe` is asserted only if the slice is the current page. After the read, bits [12:0] increment.
- R4: An address read (mode 2'b11) is driven by every slice. It returns bits [15:8] when the toggle is clear and bits [7:0] when it is set, then flips the toggle. The address is not changed.
- R5: An address write (mode 2'b10) shifts the address left by 8 and loads `din` into bits [7:0], then flips the toggle. If it is the second write of a pair (toggle set), bits [12:0] are then incremented. Two writes B1, B2 leave {B1,B2}+1.
- R6: A data write (mode 2'b00) ignores `din` and drives nothing. It only increments bits [12:0].
- R7: The increment wraps bits [12:0] from 8191 to 0. It never changes bits [15:13].
- R8: Offsets 6144 to 8191 read array index offset-6144.
- R9: A data read clears the toggle, so the next address write is taken as the high byte.
- R10: An accepted operation (chip enable low while `ready` is 1) drops `ready` for exactly 2 cycles. Chip enable is ignored while `ready` is 0. `dout_oe` is only ever high while `ready` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Active-low chip enable; one low cycle starts an operation |
| mode | input | 2 | Bit 1: address(1)/data(0); bit 0: read(1)/write(0) |
| din | input | 8 | Byte written by the CPU |
| dout | output | 8 | Byte returned during the access window |
| dout_oe | output | 1 | Output enable for `dout` onto the shared bus |
| ready | output | 1 | High when the slice can accept an operation |

## Verification
A wrong internal state shows up quickly at the ports.

- A wrong address register shows on the very next data read, as a wrong byte. It also shows on the next pair of address reads, as wrong high and low bytes. So a bad increment or a wrong wrap point is seen within one or two operations.
- A stuck byte toggle swaps the high and low bytes of the next address write or address read.
- A broken page compare shows on the next data read, as two slices driving the bus at once, or as none driving it.
- A wrong access counter shows in the same cycle, as a `ready` waveform that differs from the two-cycle window.

// File: rtl/prp_pkg.sv
package prp_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      OP_WR_DATA = 2'b00,
      OP_RD_DATA = 2'b01,
      OP_WR_ADDR = 2'b10,
      OP_RD_ADDR = 2'b11
   } prp_op_e;

   // ROM content generator: byte at array index idx for a given page id
   function automatic logic [7:0] rom_pattern(input logic [15:0] idx,
                                              input logic [2:0]  page);
      logic [15:0] t;
      t = (idx * 16'd37) ^ (idx >> 5) ^ ({13'd0, page} * 16'd69);
      return t[7:0];
   endfunction

endpackage

// File: rtl/prp_addr_reg.sv
module prp_addr_reg
   import prp_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int LOW_W  = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc,
   input  prp_op_e           op,
   input  logic [BYTE_W-1:0] din,
   output logic [ADDR_W-1:0] addr_q,
   output logic              tog_q
);

   localparam int HI_W = ADDR_W - LOW_W;

   logic [ADDR_W-1:0] addr_d;
   logic [ADDR_W-1:0] shifted;
   logic              tog_d;

   function automatic logic [ADDR_W-1:0] bump(input logic [ADDR_W-1:0] a);
      logic [LOW_W-1:0] lo;
      lo = a[LOW_W-1:0] + 1'b1;
      return {a[ADDR_W-1 -: HI_W], lo};
   endfunction

   assign shifted = {addr_q[ADDR_W-BYTE_W-1:0], din};

   always_comb begin
      addr_d = addr_q;
      tog_d  = tog_q;
      if (acc) begin
         unique case (op)
            OP_RD_DATA: begin
               addr_d = bump(addr_q);
               tog_d  = 1'b0;
            end
            OP_WR_DATA: addr_d = bump(addr_q);
            OP_WR_ADDR: begin
               addr_d = tog_q ? bump(shifted) : shifted;
               tog_d  = ~tog_q;
            end
            OP_RD_ADDR: tog_d = ~tog_q;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         tog_q  <= 1'b0;
      end else begin
         addr_q <= addr_d;
         tog_q  <= tog_d;
      end
   end

endmodule

// File: rtl/prp_rom_core.sv
module prp_rom_core
   import prp_pkg::*;
#(
   parameter int LOW_W     = 13,
   parameter int ROM_BYTES = 6144,
   parameter int PAGE_ID   = 0
) (
   input  logic [LOW_W-1:0]  loc,
   output logic [BYTE_W-1:0] q
);

   localparam logic [LOW_W-1:0] DEPTH_L = LOW_W'(ROM_BYTES);
   localparam bit FULL = (ROM_BYTES == (1 << LOW_W));

   logic [LOW_W-1:0] idx;

   generate
      if (FULL) begin : g_direct
         assign idx = loc;
      end else begin : g_fold
         // offsets past the array fold back by one array length
         assign idx = (loc >= DEPTH_L) ? (loc - DEPTH_L) : loc;
      end
   endgenerate

   assign q = rom_pattern(16'(idx), 3'(PAGE_ID));

endmodule

// File: rtl/prp_busy_timer.sv
module prp_busy_timer #(
   parameter int LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   output logic acc,
   output logic ready
);

   localparam int CNT_W = $clog2(LAT + 1);
   localparam logic [CNT_W-1:0] LAT_C = CNT_W'(LAT);

   logic [CNT_W-1:0] cnt_q;

   assign ready = (cnt_q == '0);
   assign acc   = ready & ~ce_n;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt_q <= '0;
      else if (acc)        cnt_q <= LAT_C;
      else if (!ready)     cnt_q <= cnt_q - 1'b1;
   end

endmodule

// File: rtl/paged_rom_port.sv
module paged_rom_port
   import prp_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int LOW_W     = 13,
   parameter int ROM_BYTES = 6144,
   parameter int PAGE_ID   = 0,
   parameter int LAT       = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ce_n,
   input  logic [1:0]  mode,
   input  logic [7:0]  din,
   output logic [7:0]  dout,
   output logic        dout_oe,
   output logic        ready
);

   localparam int PAGE_W = ADDR_W - LOW_W;
   localparam int NBYTES = ADDR_W / BYTE_W;

   initial begin
      assert (NBYTES == 2 && ADDR_W == NBYTES * BYTE_W)
         else $error("address register must be two bytes wide");
      assert (ROM_BYTES <= (1 << LOW_W) && 2 * ROM_BYTES >= (1 << LOW_W))
         else $error("array depth must fold with one subtraction");
      assert (PAGE_ID >= 0 && PAGE_ID < (1 << PAGE_W))
         else $error("page id does not fit page field");
      assert (LAT >= 1) else $error("access latency must be at least one");
   end

   prp_op_e            op;
   logic               acc;
   logic [ADDR_W-1:0]  addr_q;
   logic               tog_q;
   logic [BYTE_W-1:0]  rom_q;
   logic [BYTE_W-1:0]  addr_byte;
   logic               page_hit;
   logic [BYTE_W-1:0]  dout_q;
   logic               drive_q;

   assign op = prp_op_e'(mode);

   prp_busy_timer #(.LAT(LAT)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .ce_n  (ce_n),
      .acc   (acc),
      .ready (ready)
   );

   prp_addr_reg #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .acc    (acc),
      .op     (op),
      .din    (din),
      .addr_q (addr_q),
      .tog_q  (tog_q)
   );

   prp_rom_core #(.LOW_W(LOW_W), .ROM_BYTES(ROM_BYTES), .PAGE_ID(PAGE_ID)) u_rom (
      .loc (addr_q[LOW_W-1:0]),
      .q   (rom_q)
   );

   // address byte lanes, high lane first
   logic [BYTE_W-1:0] lane [NBYTES];
   generate
      for (genvar g = 0; g < NBYTES; g++) begin : g_lane
         assign lane[g] = addr_q[ADDR_W-1-g*BYTE_W -: BYTE_W];
      end
   endgenerate

   assign addr_byte = lane[tog_q];
   assign page_hit  = (addr_q[ADDR_W-1 -: PAGE_W] == PAGE_W'(PAGE_ID));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dout_q  <= '0;
         drive_q <= 1'b0;
      end else if (acc) begin
         unique case (op)
            OP_RD_DATA: begin
               dout_q  <= rom_q;
               drive_q <= page_hit;
            end
            OP_RD_ADDR: begin
               dout_q  <= addr_byte;
               drive_q <= 1'b1;
            end
            default: drive_q <= 1'b0;
         endcase
      end
   end

   assign dout    = dout_q;
   assign dout_oe = drive_q & ~ready;

endmodule

// File: rtl/paged_rom_port_chk.sv
module paged_rom_port_chk
   import prp_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int LOW_W   = 13,
   parameter int PAGE_ID = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic [1:0]        mode,
   input logic [7:0]        din,
   input logic              ready,
   input logic              dout_oe,
   input logic [ADDR_W-1:0] addr_q,
   input logic              tog_q
);

   localparam int PAGE_W = ADDR_W - LOW_W;

   logic acc_c, hit_c;
   assign acc_c = ready && !ce_n;
   assign hit_c = (addr_q[ADDR_W-1 -: PAGE_W] == PAGE_W'(PAGE_ID));

   p_rd_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      acc_c && mode == OP_RD_DATA && !hit_c |=> !dout_oe);

   p_rd_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      acc_c && mode == OP_RD_DATA && hit_c |=> dout_oe);

   p_addr_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
      acc_c && mode == OP_RD_ADDR |=> dout_oe && $stable(addr_q));

   p_first_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
      acc_c && mode == OP_WR_ADDR && !tog_q |=> addr_q[7:0] == $past(din) && tog_q);

   p_wdata_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      acc_c && mode == OP_WR_DATA |=> !dout_oe);

   p_page_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      acc_c && mode != OP_WR_ADDR |=> $stable(addr_q[ADDR_W-1 -: PAGE_W]));

   p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      acc_c && mode == OP_RD_DATA && (&addr_q[LOW_W-1:0]) |=> addr_q[LOW_W-1:0] == '0);

   p_tog_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      acc_c && mode == OP_RD_DATA |=> !tog_q);

   p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      acc_c |=> !ready);

   p_oe_in_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
      dout_oe |-> !ready);

   p_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |=> $stable(addr_q) && $stable(tog_q));

endmodule

bind paged_rom_port paged_rom_port_chk #(
   .ADDR_W (ADDR_W),
   .LOW_W  (LOW_W),
   .PAGE_ID(PAGE_ID)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ce_n    (ce_n),
   .mode    (mode),
   .din     (din),
   .ready   (ready),
   .dout_oe (dout_oe),
   .addr_q  (addr_q),
   .tog_q   (tog_q)
);

// File: tb/sim_paged_rom_port.sv
module sim_paged_rom_port;

   localparam logic [1:0] WD = 2'b00, RD = 2'b01, WA = 2'b10, RA = 2'b11;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       ce_n  = 1'b1;
   logic [1:0] mode  = 2'b00;
   logic [7:0] din   = 8'h00;
   logic [7:0] dout0, dout1;
   logic       oe0, oe1, rdy0, rdy1;

   int errs = 0, checks = 0;
   bit done = 0;

   paged_rom_port #(.PAGE_ID(3)) u0 (.clk(clk), .rst_n(rst_n), .ce_n(ce_n), .mode(mode),
      .din(din), .dout(dout0), .dout_oe(oe0), .ready(rdy0));
   paged_rom_port #(.PAGE_ID(5)) u1 (.clk(clk), .rst_n(rst_n), .ce_n(ce_n), .mode(mode),
      .din(din), .dout(dout1), .dout_oe(oe1), .ready(rdy1));

   function automatic int rom_ref(int pg, int i);
      return ((i * 37) ^ (i >> 5) ^ (pg * 69)) & 255;
   endfunction

   task automatic check(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", what, act, exp, $time);
      end
   endtask

   // behavioural reference: two slices, page 3 and page 5
   int m_cnt = 0, m_addr = 0, m_tog = 0, m_b0 = 0, m_b1 = 0;
   bit m_drv0 = 0, m_drv1 = 0;

   function automatic int step(int a);
      return (a & 'hE000) | (((a & 8191) + 1) & 8191);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_addr = 0; m_tog = 0; m_drv0 = 0; m_drv1 = 0;
      end else if (m_cnt > 0) begin
         m_cnt--;
      end else if (!ce_n) begin
         m_cnt = 2;
         case (mode)
            RD: begin
               int lo, ix;
               lo = m_addr & 8191;
               ix = (lo >= 6144) ? lo - 6144 : lo;
               m_b0 = rom_ref(3, ix); m_b1 = rom_ref(5, ix);
               m_drv0 = ((m_addr >> 13) == 3); m_drv1 = ((m_addr >> 13) == 5);
               m_addr = step(m_addr); m_tog = 0;
            end
            RA: begin
               m_b0 = m_tog ? (m_addr & 255) : (m_addr >> 8); m_b1 = m_b0;
               m_drv0 = 1; m_drv1 = 1; m_tog ^= 1;
            end
            WA: begin
               m_addr = ((m_addr << 8) | din) & 'hFFFF;
               if (m_tog) m_addr = step(m_addr);
               m_tog ^= 1; m_drv0 = 0; m_drv1 = 0;
            end
            default: begin
               m_addr = step(m_addr); m_drv0 = 0; m_drv1 = 0;
            end
         endcase
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(rdy0 == (m_cnt == 0) && rdy1 == rdy0, "R10 ready vs model", rdy0, m_cnt == 0);
         check(oe0 == (m_drv0 && m_cnt != 0), "R3 R4 oe0 vs model", oe0, m_drv0 && m_cnt != 0);
         check(oe1 == (m_drv1 && m_cnt != 0), "R3 R4 oe1 vs model", oe1, m_drv1 && m_cnt != 0);
         if (oe0) check(dout0 == m_b0[7:0], "R3 R4 dout0 vs model", dout0, m_b0);
         if (oe1) check(dout1 == m_b1[7:0], "R3 R4 dout1 vs model", dout1, m_b1);
      end
   end

   logic [7:0] c_d0, c_d1;
   logic       c_oe0, c_oe1, c_ra, c_rb, c_rc;

   task automatic do_op(input logic [1:0] md, input logic [7:0] b);
      @(negedge clk);
      while (!rdy0) @(negedge clk);
      mode = md; din = b; ce_n = 1'b0;
      @(negedge clk);
      ce_n = 1'b1;
      c_d0 = dout0; c_d1 = dout1; c_oe0 = oe0; c_oe1 = oe1; c_ra = rdy0;
      @(negedge clk); c_rb = rdy0;
      @(negedge clk); c_rc = rdy0;
   endtask

   task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo);
      do_op(WA, hi);
      do_op(WA, lo);
   endtask

   task automatic expect_addr(input logic [7:0] hi, input logic [7:0] lo, input string tag);
      do_op(RA, 8'h00);
      check(c_d0 == hi && c_oe0 && c_oe1, {tag, " address high byte"}, c_d0, hi);
      do_op(RA, 8'h00);
      check(c_d0 == lo && c_oe0 && c_oe1, {tag, " address low byte"}, c_d0, lo);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(rdy0 == 1'b1, "R1 ready after reset", rdy0, 1);
      check(oe0 == 1'b0 && oe1 == 1'b0, "R1 oe after reset", oe0, 0);
      expect_addr(8'h00, 8'h00, "R1");
      check(c_ra == 0 && c_rb == 0 && c_rc == 1, "R10 two-cycle window",
            {c_ra, c_rb, c_rc}, 3'b001);

      do_op(RD, 8'h00);
      check(c_oe0 == 0 && c_oe1 == 0, "R3 page 0 nobody drives", c_oe0, 0);

      set_addr(8'h60, 8'h10);
      expect_addr(8'h60, 8'h11, "R5 pair load plus one");

      do_op(RD, 8'h00);
      check(c_oe0 == 1 && c_oe1 == 0, "R2 page 3 selects u0 only", {c_oe0, c_oe1}, 2'b10);
      check(c_d0 == rom_ref(3, 'h11), "R3 read byte 0x11", c_d0, rom_ref(3, 'h11));
      do_op(RD, 8'h00);
      check(c_d0 == rom_ref(3, 'h12), "R3 read increments", c_d0, rom_ref(3, 'h12));

      do_op(WD, 8'hFF);
      check(c_oe0 == 0 && c_oe1 == 0, "R6 write data drives nothing", c_oe0, 0);
      do_op(RD, 8'h00);
      check(c_d0 == rom_ref(3, 'h14), "R6 write data increments", c_d0, rom_ref(3, 'h14));

      set_addr(8'hA0, 8'h00);
      do_op(RD, 8'h00);
      check(c_oe0 == 0 && c_oe1 == 1, "R2 page 5 selects u1 only", {c_oe0, c_oe1}, 2'b01);
      check(c_d1 == rom_ref(5, 1), "R3 u1 read byte", c_d1, rom_ref(5, 1));

      set_addr(8'hE0, 8'h05);
      do_op(RD, 8'h00);
      check(c_oe0 == 0 && c_oe1 == 0, "R3 unmatched page silent", {c_oe0, c_oe1}, 0);

      set_addr(8'h7F, 8'hFE);
      do_op(RD, 8'h00);
      check(c_d0 == rom_ref(3, 2047), "R8 offset 8191 folds", c_d0, rom_ref(3, 2047));
      expect_addr(8'h60, 8'h00, "R7 wrap keeps page");

      set_addr(8'h77, 8'hFF);
      do_op(RD, 8'h00);
      check(c_d0 == rom_ref(3, 0), "R8 offset 6144 folds to 0", c_d0, rom_ref(3, 0));

      do_op(WA, 8'h12);
      do_op(RD, 8'h00);
      set_addr(8'h60, 8'h20);
      expect_addr(8'h60, 8'h21, "R9 toggle cleared by read");

      // R10: chip enable held low into the busy window is ignored
      @(negedge clk);
      while (!rdy0) @(negedge clk);
      mode = RD; ce_n = 1'b0;
      @(negedge clk);
      mode = WD;
      @(negedge clk);
      ce_n = 1'b1;
      @(negedge clk);
      expect_addr(8'h60, 8'h22, "R10 busy chip enable ignored");

      repeat (3) @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         done = 1;
         errs++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

endmodule